// File: doc/BRIEF.md
# SMI Source Enable and Gating Register

This block holds the 32-bit power-management word that chooses which event sources are allowed to raise the system-management interrupt request. Software writes the whole word through a plain write strobe, and the stored enables read back on a combinational read bus. Status levels and single-cycle event strobes arrive from the surrounding logic. Each is masked by its own enable bit, and the survivors are ORed into one SMI request.

Three bits behave specially. The watchdog-logic enable can be frozen by a lock input from the watchdog block. The release bit is write-only: it stores nothing, and writing a one to it emits a single-cycle SCI pulse. The sleep-intercept enable turns a software request to enter sleep into an SMI, and it withholds the sleep permit for that request. A rerouted NMI raises SMI whenever rerouting is enabled, whatever the watchdog enable holds.

Top module: `smi_gate_reg`

## Requirements
- R1: After a synchronous reset the read bus returns 00000000h, `smi_req` is low and `sci_pulse` is low.
- R2: Only bits 14, 13, 11, 6, 5, 4 and 3 store written values and read them back. Bits 31:15, 12, 10:8, 7 and 2:0 always read 0, whatever is written to them.
- R3: While `lock_in` is high, a write leaves bit 13 at its old value, and the other storable bits still take the written data.
- R4: Bit 7 reads 0. A write with bit 7 at 1 drives `sci_pulse` high for exactly the clock cycle after the write. A write with bit 7 at 0 produces no pulse.
- R5: `periodic_sts` raises `smi_req` only while bit 14 is set.
- R6: `wdog_sts` raises `smi_req` only while bit 13 is set.
- R7: `nmi_sts` raises `smi_req` whenever `nmi_route_en` is high, even with bit 13 clear. With `nmi_route_en` low it has no effect.
- R8: An `apm_wr` strobe raises `smi_req` in the same cycle only while bit 5 is set.
- R9: While bit 11 is set, an `io_access` strobe whose `io_addr` equals 0062h or 0066h raises `smi_req` in the same cycle. Any other address, or an address without the strobe, does not raise it.
- R10: A `sleep_wr` strobe asserts `sleep_go` when bit 4 is clear and adds nothing to `smi_req`. When bit 4 is set, the strobe raises `smi_req` and holds `sleep_go` low.
- R11: `swtmr_sts` is gated by bit 6 and `usb_sts` by bit 3, and either one raises `smi_req` while its bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value |
| lock_in | input | 1 | Freezes bit 13 against writes |
| nmi_route_en | input | 1 | NMI-to-SMI reroute enable |
| periodic_sts | input | 1 | Periodic event status level |
| wdog_sts | input | 1 | Watchdog-logic event status level |
| nmi_sts | input | 1 | Rerouted NMI event level |
| swtmr_sts | input | 1 | Software timer expiry status level |
| usb_sts | input | 1 | Legacy USB event status level |
| apm_wr | input | 1 | Strobe: write to APM command port |
| io_access | input | 1 | Strobe: I/O access seen |
| io_addr | input | 16 | Address of the I/O access |
| sleep_wr | input | 1 | Strobe: software wrote 1 to sleep enable |
| smi_req | output | 1 | Combined SMI request |
| sci_pulse | output | 1 | One-cycle SCI pulse from the release bit |
| sleep_go | output | 1 | Sleep transition permitted |

## Verification
The bench builds the block with its default parameters: a 16-bit I/O address and trap ports at 0062h and 0066h. With these values the neighbouring address 0064h can act as a near-miss case for the trap decode. A behavioural model predicts the read value, `smi_req`, `sleep_go` and `sci_pulse` on every clock. The lock is exercised on bit 13 while the other bits change in the same write. Each source is driven with its enable both clear and set, and the rerouted NMI is driven with bit 13 clear.

// File: rtl/smi_pkg.sv
package smi_pkg;

    localparam int REG_W  = 32;
    localparam int B_PER  = 14;
    localparam int B_WDG  = 13;
    localparam int B_UCON = 11;
    localparam int B_RLS  = 7;
    localparam int B_SWT  = 6;
    localparam int B_APM  = 5;
    localparam int B_SLP  = 4;
    localparam int B_USB  = 3;

    // storable enable bits
    localparam logic [REG_W-1:0] STORE_MASK =
        (32'd1 << B_PER) | (32'd1 << B_WDG) | (32'd1 << B_UCON) |
        (32'd1 << B_SWT) | (32'd1 << B_APM) | (32'd1 << B_SLP) |
        (32'd1 << B_USB);

    typedef struct packed {
        logic periodic;
        logic wdog;
        logic ucon;
        logic swtmr;
        logic apm;
        logic slp;
        logic usb;
    } smi_en_t;

    typedef struct packed {
        logic periodic;
        logic wdog;
        logic nmi;
        logic ucon;
        logic swtmr;
        logic apm;
        logic slp;
        logic usb;
    } smi_src_t;

    function automatic smi_en_t unpack_en(input logic [REG_W-1:0] w);
        smi_en_t e;
        e.periodic = w[B_PER];
        e.wdog     = w[B_WDG];
        e.ucon     = w[B_UCON];
        e.swtmr    = w[B_SWT];
        e.apm      = w[B_APM];
        e.slp      = w[B_SLP];
        e.usb      = w[B_USB];
        return e;
    endfunction

    function automatic logic [REG_W-1:0] pack_en(input smi_en_t e);
        logic [REG_W-1:0] w;
        w          = '0;
        w[B_PER]   = e.periodic;
        w[B_WDG]   = e.wdog;
        w[B_UCON]  = e.ucon;
        w[B_SWT]   = e.swtmr;
        w[B_APM]   = e.apm;
        w[B_SLP]   = e.slp;
        w[B_USB]   = e.usb;
        return w;
    endfunction

endpackage

// File: rtl/smi_en_store.sv
module smi_en_store
    import smi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             lock_in,
    output smi_en_t          en_q,
    output logic             rls_pulse
);
    smi_en_t en_nxt;

    always_comb begin
        en_nxt = unpack_en(wr_data);
        if (lock_in) begin
            en_nxt.wdog = en_q.wdog;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            rls_pulse <= 1'b0;
        end else begin
            rls_pulse <= wr_en & wr_data[B_RLS];
            if (wr_en) begin
                en_q <= en_nxt;
            end
        end
    end
endmodule

// File: rtl/smi_port_match.sv
module smi_port_match #(
    parameter int                     ADDR_W = 16,
    parameter int                     NPORT  = 2,
    parameter logic [NPORT*ADDR_W-1:0] PORTS = {16'h0066, 16'h0062}
) (
    input  logic              io_access,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              hit
);
    logic [NPORT-1:0] match;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        assign match[i] = (io_addr == PORTS[i*ADDR_W +: ADDR_W]);
    end

    assign hit = io_access & (|match);
endmodule

// File: rtl/smi_src_gate.sv
module smi_src_gate
    import smi_pkg::*;
(
    input  smi_en_t  en,
    input  smi_src_t src,
    input  logic     nmi_route_en,
    output logic     smi,
    output logic     sleep_go
);
    smi_src_t allowed;
    smi_src_t gated;

    always_comb begin
        allowed.periodic = en.periodic;
        allowed.wdog     = en.wdog;
        allowed.nmi      = nmi_route_en;
        allowed.ucon     = en.ucon;
        allowed.swtmr    = en.swtmr;
        allowed.apm      = en.apm;
        allowed.slp      = en.slp;
        allowed.usb      = en.usb;
        gated            = src & allowed;
    end

    assign smi      = |gated;
    assign sleep_go = src.slp & ~en.slp;
endmodule

// File: rtl/smi_gate_reg.sv
module smi_gate_reg
    import smi_pkg::*;
#(
    parameter int               ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] TRAP_PORT_A = 16'h0062,
    parameter logic [ADDR_W-1:0] TRAP_PORT_B = 16'h0066
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              lock_in,
    input  logic              nmi_route_en,
    input  logic              periodic_sts,
    input  logic              wdog_sts,
    input  logic              nmi_sts,
    input  logic              swtmr_sts,
    input  logic              usb_sts,
    input  logic              apm_wr,
    input  logic              io_access,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              sleep_wr,
    output logic              smi_req,
    output logic              sci_pulse,
    output logic              sleep_go
);
    localparam int NPORT = 2;
    localparam logic [NPORT*ADDR_W-1:0] TRAP_LIST = {TRAP_PORT_B, TRAP_PORT_A};

    smi_en_t  en_q;
    smi_src_t src;
    logic     trap_hit;

    smi_en_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .lock_in   (lock_in),
        .en_q      (en_q),
        .rls_pulse (sci_pulse)
    );

    smi_port_match #(
        .ADDR_W (ADDR_W),
        .NPORT  (NPORT),
        .PORTS  (TRAP_LIST)
    ) u_match (
        .io_access (io_access),
        .io_addr   (io_addr),
        .hit       (trap_hit)
    );

    always_comb begin
        src.periodic = periodic_sts;
        src.wdog     = wdog_sts;
        src.nmi      = nmi_sts;
        src.ucon     = trap_hit;
        src.swtmr    = swtmr_sts;
        src.apm      = apm_wr;
        src.slp      = sleep_wr;
        src.usb      = usb_sts;
    end

    smi_src_gate u_gate (
        .en           (en_q),
        .src          (src),
        .nmi_route_en (nmi_route_en),
        .smi          (smi_req),
        .sleep_go     (sleep_go)
    );

    assign rd_data = pack_en(en_q);
endmodule

// File: rtl/smi_gate_chk.sv
module smi_gate_chk
    import smi_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             lock_in,
    input logic             nmi_route_en,
    input logic             nmi_sts,
    input logic             apm_wr,
    input logic             sleep_wr,
    input logic             smi_req,
    input logic             sci_pulse,
    input logic             sleep_go
);
    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~STORE_MASK) == '0);

    assert_lock_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (lock_in && wr_en) |=> $stable(rd_data[B_WDG]));

    assert_sci_cause_R4: assert property (@(posedge clk) disable iff (rst)
        sci_pulse |-> $past(wr_en && wr_data[B_RLS]));

    assert_nmi_bypass_R7: assert property (@(posedge clk) disable iff (rst)
        (nmi_sts && nmi_route_en) |-> smi_req);

    assert_apm_smi_R8: assert property (@(posedge clk) disable iff (rst)
        (apm_wr && rd_data[B_APM]) |-> smi_req);

    assert_sleep_block_R10: assert property (@(posedge clk) disable iff (rst)
        (sleep_wr && rd_data[B_SLP]) |-> (smi_req && !sleep_go));
endmodule

bind smi_gate_reg smi_gate_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .lock_in      (lock_in),
    .nmi_route_en (nmi_route_en),
    .nmi_sts      (nmi_sts),
    .apm_wr       (apm_wr),
    .sleep_wr     (sleep_wr),
    .smi_req      (smi_req),
    .sci_pulse    (sci_pulse),
    .sleep_go     (sleep_go)
);

// File: tb/sim_smi_gate_reg.sv
`timescale 1ns/1ps
module sim_smi_gate_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        lock_in = 1'b0, nmi_route_en = 1'b0;
    logic        periodic_sts = 1'b0, wdog_sts = 1'b0, nmi_sts = 1'b0;
    logic        swtmr_sts = 1'b0, usb_sts = 1'b0, apm_wr = 1'b0;
    logic        io_access = 1'b0, sleep_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic        smi_req, sci_pulse, sleep_go;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    smi_gate_reg u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .lock_in(lock_in), .nmi_route_en(nmi_route_en), .periodic_sts(periodic_sts),
        .wdog_sts(wdog_sts), .nmi_sts(nmi_sts), .swtmr_sts(swtmr_sts), .usb_sts(usb_sts),
        .apm_wr(apm_wr), .io_access(io_access), .io_addr(io_addr), .sleep_wr(sleep_wr),
        .smi_req(smi_req), .sci_pulse(sci_pulse), .sleep_go(sleep_go)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [31:0] m_reg = '0;
    logic        m_sci = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_reg <= '0;
            m_sci <= 1'b0;
        end else begin
            m_sci <= wr_en && wr_data[7];
            if (wr_en) begin
                if (lock_in)
                    m_reg <= (wr_data & 32'h0000_4878) | (m_reg & 32'h0000_2000);
                else
                    m_reg <= wr_data & 32'h0000_6878;
            end
        end
    end

    always @(posedge clk) begin
        logic e_smi, e_go;
        #5;
        if (!rst) begin
            e_smi = (periodic_sts && m_reg[14]) || (wdog_sts && m_reg[13]) ||
                    (nmi_sts && nmi_route_en) ||
                    (io_access && (io_addr == 16'h0062 || io_addr == 16'h0066) && m_reg[11]) ||
                    (swtmr_sts && m_reg[6]) || (apm_wr && m_reg[5]) ||
                    (sleep_wr && m_reg[4]) || (usb_sts && m_reg[3]);
            e_go  = sleep_wr && !m_reg[4];
            chk("R2 model rd_data", rd_data, m_reg);
            chk("R4 model sci_pulse", {31'd0, sci_pulse}, {31'd0, m_sci});
            chk("R5-R11 model smi_req", {31'd0, smi_req}, {31'd0, e_smi});
            chk("R10 model sleep_go", {31'd0, sleep_go}, {31'd0, e_go});
        end
    end

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic settle();
        #2;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset rd_data", rd_data, 32'h0);
        chk("R1 reset smi", {31'd0, smi_req}, 32'h0);
        chk("R1 reset sci", {31'd0, sci_pulse}, 32'h0);

        wr(32'hFFFF_FFFF);
        chk("R2 store mask", rd_data, 32'h0000_6878);
        chk("R4 sci after write 1", {31'd0, sci_pulse}, 32'h1);
        @(negedge clk);
        chk("R4 sci one cycle", {31'd0, sci_pulse}, 32'h0);
        wr(32'h0000_0000);
        chk("R2 clear", rd_data, 32'h0);
        chk("R4 no sci on write 0", {31'd0, sci_pulse}, 32'h0);
        wr(32'h0000_1780);
        chk("R2 reserved ignored", rd_data, 32'h0);

        wr(32'h0000_2000);
        chk("R3 unlocked set", rd_data, 32'h0000_2000);
        lock_in = 1'b1;
        wr(32'h0000_0028);
        chk("R3 locked keep bit13", rd_data, 32'h0000_2028);
        wr(32'h0000_0000);
        chk("R3 locked clear others", rd_data, 32'h0000_2000);
        lock_in = 1'b0;
        wr(32'h0000_0000);
        chk("R3 unlock clear", rd_data, 32'h0);
        lock_in = 1'b1;
        wr(32'h0000_2000);
        chk("R3 locked no set", rd_data, 32'h0);
        lock_in = 1'b0;

        periodic_sts = 1'b1; settle();
        chk("R5 periodic gated off", {31'd0, smi_req}, 32'h0);
        periodic_sts = 1'b0;
        wr(32'h0000_4000);
        periodic_sts = 1'b1; settle();
        chk("R5 periodic on", {31'd0, smi_req}, 32'h1);
        periodic_sts = 1'b0;

        wdog_sts = 1'b1; settle();
        chk("R6 wdog gated off", {31'd0, smi_req}, 32'h0);
        wdog_sts = 1'b0;
        wr(32'h0000_2000);
        wdog_sts = 1'b1; settle();
        chk("R6 wdog on", {31'd0, smi_req}, 32'h1);
        wdog_sts = 1'b0;

        wr(32'h0);
        nmi_sts = 1'b1; settle();
        chk("R7 nmi no route", {31'd0, smi_req}, 32'h0);
        nmi_route_en = 1'b1; settle();
        chk("R7 nmi bypass", {31'd0, smi_req}, 32'h1);
        @(negedge clk);
        nmi_sts = 1'b0; nmi_route_en = 1'b0;

        apm_wr = 1'b1; settle();
        chk("R8 apm gated off", {31'd0, smi_req}, 32'h0);
        apm_wr = 1'b0;
        wr(32'h0000_0020);
        apm_wr = 1'b1; settle();
        chk("R8 apm on", {31'd0, smi_req}, 32'h1);
        apm_wr = 1'b0;

        wr(32'h0000_0800);
        io_access = 1'b1; io_addr = 16'h0062; settle();
        chk("R9 trap 62", {31'd0, smi_req}, 32'h1);
        io_addr = 16'h0066; settle();
        chk("R9 trap 66", {31'd0, smi_req}, 32'h1);
        io_addr = 16'h0064; settle();
        chk("R9 other port", {31'd0, smi_req}, 32'h0);
        io_access = 1'b0; io_addr = 16'h0062; settle();
        chk("R9 no strobe", {31'd0, smi_req}, 32'h0);
        io_addr = '0;

        wr(32'h0);
        sleep_wr = 1'b1; settle();
        chk("R10 sleep go", {31'd0, sleep_go}, 32'h1);
        chk("R10 sleep no smi", {31'd0, smi_req}, 32'h0);
        sleep_wr = 1'b0;
        wr(32'h0000_0010);
        sleep_wr = 1'b1; settle();
        chk("R10 sleep blocked", {31'd0, sleep_go}, 32'h0);
        chk("R10 sleep smi", {31'd0, smi_req}, 32'h1);
        sleep_wr = 1'b0;

        wr(32'h0000_0040);
        swtmr_sts = 1'b1; settle();
        chk("R11 swtmr on", {31'd0, smi_req}, 32'h1);
        swtmr_sts = 1'b0; usb_sts = 1'b1; settle();
        chk("R11 usb gated off", {31'd0, smi_req}, 32'h0);
        usb_sts = 1'b0;
        wr(32'h0000_0008);
        usb_sts = 1'b1; settle();
        chk("R11 usb on", {31'd0, smi_req}, 32'h1);
        usb_sts = 1'b0;

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule